// File: doc/BRIEF.md
# Thermal Cooldown Power-Cut Controller

This block guards a board against overheating. It compares two signed temperature readings against fixed limits: one from a sensor on the board and one from an external sensor such as a processor junction diode. When either reading is over its limit, the block drops the primary power enable for a cooldown interval counted in seconds. It then raises the enable again and records which sensor caused the cut.

The cooldown interval adapts. Each trip lengthens the next interval by a fixed step, up to a ceiling. When power has stayed on for a set quiet span after a restore with no further trip, the interval falls back to its minimum. Time is counted from a one-cycle seconds tick that the surrounding logic supplies. The protection is active only while its enable input is high.

Top module: `thermal_guard`

## Requirements
- R1: While `prot_en`=1 and `pwr_en`=1, a valid board reading strictly greater than BOARD_LIMIT (default 850, signed, units of 0.1 °C) drives `pwr_en` low on the next clock edge and sets `reset_cause` to 4.
- R2: Under the same conditions, a valid external reading strictly greater than EXT_LIMIT (default 1000) with no board trip drives `pwr_en` low on the next edge and sets `reset_cause` to 5.
- R3: When both readings are over their limits in the same cycle, `reset_cause` becomes 4.
- R4: Comparisons are signed and strict. A reading equal to or below its limit, a negative reading, or a reading whose valid strobe is low causes no trip.
- R5: After a trip, `pwr_en` returns high on the clock edge that samples the Nth `sec_tick`, where N is the cooldown period in force at the trip. After reset, N equals MIN_S (default 5).
- R6: Each trip raises the period for the next trip by STEP_S (default 30), clamped at MAX_S (default 300). The period never falls below MIN_S.
- R7: If QUIET_S (default 300) ticks are seen with power on after a restore and no trip occurs, the period returns to MIN_S. A trip after fewer ticks still uses the grown period.
- R8: While `prot_en`=0, no reading drives `pwr_en` low.
- R9: While `pwr_en`=0, over-limit readings are ignored: `reset_cause` and the next cooldown period are unchanged.
- R10: Reset leaves `pwr_en`=1, `reset_cause`=0 and the period at MIN_S. `reset_cause` holds its value from the last trip, including after power is restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prot_en | input | 1 | Protection enable |
| board_vld | input | 1 | Board reading valid strobe |
| board_temp | input | TEMP_W | Board temperature, signed, 0.1 °C |
| ext_vld | input | 1 | External reading valid strobe |
| ext_temp | input | TEMP_W | External temperature, signed, 0.1 °C |
| sec_tick | input | 1 | One-cycle pulse per second |
| pwr_en | output | 1 | Primary power enable |
| reset_cause | output | 4 | Cause of the last controller cut (0 none, 4 board, 5 external) |

## Verification
A reading presented in one cycle shows its effect on `pwr_en` and `reset_cause` one clock edge later. The bench drives each reading on a falling edge and checks both outputs on the next falling edge. A restore is due on the edge that samples the last tick of the cooldown. The bench therefore pulses each tick for one cycle and checks `pwr_en` after every tick: it must be low for the first N-1 ticks and high after the Nth. The period is never read directly. The bench infers it from cooldown lengths, which it predicts arithmetically from the step, the clamp and the number of quiet ticks it has issued.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;
  typedef enum logic [3:0] {
    CAUSE_NONE  = 4'd0,
    CAUSE_BOARD = 4'd4,
    CAUSE_EXT   = 4'd5
  } cause_e;
endpackage

// File: rtl/tg_trip_detect.sv
module tg_trip_detect
  import thermal_guard_pkg::*;
#(
  parameter int TEMP_W      = 16,
  parameter int BOARD_LIMIT = 850,
  parameter int EXT_LIMIT   = 1000
) (
  input  logic                     prot_en,
  input  logic                     pwr_on,
  input  logic                     board_vld,
  input  logic signed [TEMP_W-1:0] board_temp,
  input  logic                     ext_vld,
  input  logic signed [TEMP_W-1:0] ext_temp,
  output logic                     trip,
  output cause_e                   trip_cause
);
  localparam logic signed [TEMP_W-1:0] BOARD_LIM_V = TEMP_W'(BOARD_LIMIT);
  localparam logic signed [TEMP_W-1:0] EXT_LIM_V   = TEMP_W'(EXT_LIMIT);

  logic board_hot;
  logic ext_hot;

  always_comb begin
    board_hot  = board_vld && (board_temp > BOARD_LIM_V);
    ext_hot    = ext_vld && (ext_temp > EXT_LIM_V);
    trip       = prot_en && pwr_on && (board_hot || ext_hot);
    // board sensor takes precedence when both are hot
    trip_cause = board_hot ? CAUSE_BOARD : CAUSE_EXT;
  end
endmodule

// File: rtl/tg_period_ctrl.sv
module tg_period_ctrl #(
  parameter int MIN_S   = 5,
  parameter int MAX_S   = 300,
  parameter int STEP_S  = 30,
  parameter int QUIET_S = 300,
  parameter int SEC_W   = 9,
  parameter int QUIET_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trip,
  input  logic             restore,
  input  logic             pwr_on,
  input  logic             sec_tick,
  output logic [SEC_W-1:0] period
);
  localparam logic [SEC_W-1:0]   MIN_V     = SEC_W'(MIN_S);
  localparam logic [SEC_W-1:0]   MAX_V     = SEC_W'(MAX_S);
  localparam logic [SEC_W:0]     MAX_WIDE  = (SEC_W+1)'(MAX_S);
  localparam logic [SEC_W:0]     STEP_WIDE = (SEC_W+1)'(STEP_S);
  localparam logic [QUIET_W-1:0] QUIET_END = QUIET_W'(QUIET_S - 1);

  logic [SEC_W-1:0]   period_q, period_d;
  logic [QUIET_W-1:0] quiet_q, quiet_d;
  logic               armed_q, armed_d;
  logic [SEC_W:0]     grown;

  always_comb begin
    grown    = {1'b0, period_q} + STEP_WIDE;
    period_d = period_q;
    quiet_d  = quiet_q;
    armed_d  = armed_q;
    if (trip) begin
      period_d = (grown > MAX_WIDE) ? MAX_V : grown[SEC_W-1:0];
      armed_d  = 1'b0;
      quiet_d  = '0;
    end else if (restore) begin
      armed_d = 1'b1;
      quiet_d = '0;
    end else if (armed_q && pwr_on && sec_tick) begin
      if (quiet_q == QUIET_END) begin
        period_d = MIN_V;
        armed_d  = 1'b0;
        quiet_d  = '0;
      end else begin
        quiet_d = quiet_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= MIN_V;
      quiet_q  <= '0;
      armed_q  <= 1'b0;
    end else begin
      period_q <= period_d;
      quiet_q  <= quiet_d;
      armed_q  <= armed_d;
    end
  end

  assign period = period_q;
endmodule

// File: rtl/tg_cooldown_timer.sv
module tg_cooldown_timer #(
  parameter int SEC_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trip,
  input  logic             sec_tick,
  input  logic [SEC_W-1:0] period,
  output logic             pwr_on,
  output logic             restore
);
  localparam logic [SEC_W-1:0] ONE = SEC_W'(1);

  logic             pwr_q, pwr_d;
  logic [SEC_W-1:0] remain_q, remain_d;

  always_comb begin
    restore  = !pwr_q && sec_tick && (remain_q <= ONE);
    pwr_d    = pwr_q;
    remain_d = remain_q;
    if (trip) begin
      pwr_d    = 1'b0;
      remain_d = period;
    end else if (!pwr_q && sec_tick) begin
      if (restore) begin
        pwr_d    = 1'b1;
        remain_d = '0;
      end else begin
        remain_d = remain_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q    <= 1'b1;
      remain_q <= '0;
    end else begin
      pwr_q    <= pwr_d;
      remain_q <= remain_d;
    end
  end

  assign pwr_on = pwr_q;
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
  import thermal_guard_pkg::*;
#(
  parameter int TEMP_W      = 16,
  parameter int BOARD_LIMIT = 850,
  parameter int EXT_LIMIT   = 1000,
  parameter int MIN_S       = 5,
  parameter int MAX_S       = 300,
  parameter int STEP_S      = 30,
  parameter int QUIET_S     = 300
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     prot_en,
  input  logic                     board_vld,
  input  logic signed [TEMP_W-1:0] board_temp,
  input  logic                     ext_vld,
  input  logic signed [TEMP_W-1:0] ext_temp,
  input  logic                     sec_tick,
  output logic                     pwr_en,
  output logic [3:0]               reset_cause
);
  localparam int SEC_W   = $clog2(MAX_S + 1);
  localparam int QUIET_W = $clog2(QUIET_S + 1);

  logic             rst_meta, rst_sync_n;
  logic             trip, restore, pwr_on;
  cause_e           trip_cause;
  cause_e           cause_q, cause_d;
  logic [SEC_W-1:0] cool_period;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  tg_trip_detect #(
    .TEMP_W(TEMP_W), .BOARD_LIMIT(BOARD_LIMIT), .EXT_LIMIT(EXT_LIMIT)
  ) u_detect (
    .prot_en(prot_en), .pwr_on(pwr_on),
    .board_vld(board_vld), .board_temp(board_temp),
    .ext_vld(ext_vld), .ext_temp(ext_temp),
    .trip(trip), .trip_cause(trip_cause)
  );

  tg_period_ctrl #(
    .MIN_S(MIN_S), .MAX_S(MAX_S), .STEP_S(STEP_S), .QUIET_S(QUIET_S),
    .SEC_W(SEC_W), .QUIET_W(QUIET_W)
  ) u_period (
    .clk(clk), .rst_n(rst_sync_n), .trip(trip), .restore(restore),
    .pwr_on(pwr_on), .sec_tick(sec_tick), .period(cool_period)
  );

  tg_cooldown_timer #(.SEC_W(SEC_W)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .trip(trip), .sec_tick(sec_tick),
    .period(cool_period), .pwr_on(pwr_on), .restore(restore)
  );

  always_comb begin
    cause_d = cause_q;
    if (trip) cause_d = trip_cause;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cause_q <= CAUSE_NONE;
    else             cause_q <= cause_d;
  end

  assign pwr_en      = pwr_on;
  assign reset_cause = cause_q;
endmodule

// File: rtl/thermal_guard_chk.sv
module thermal_guard_chk #(
  parameter int TEMP_W      = 16,
  parameter int BOARD_LIMIT = 850,
  parameter int EXT_LIMIT   = 1000,
  parameter int MIN_S       = 5,
  parameter int MAX_S       = 300,
  parameter int SEC_W       = 9
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     prot_en,
  input logic                     board_vld,
  input logic signed [TEMP_W-1:0] board_temp,
  input logic                     ext_vld,
  input logic signed [TEMP_W-1:0] ext_temp,
  input logic                     sec_tick,
  input logic                     pwr_en,
  input logic [3:0]               reset_cause,
  input logic [SEC_W-1:0]         period
);
  localparam logic signed [TEMP_W-1:0] BL = TEMP_W'(BOARD_LIMIT);
  localparam logic signed [TEMP_W-1:0] EL = TEMP_W'(EXT_LIMIT);
  localparam logic [SEC_W-1:0] LO = SEC_W'(MIN_S);
  localparam logic [SEC_W-1:0] HI = SEC_W'(MAX_S);

  logic bhot, ehot;
  assign bhot = board_vld && (board_temp > BL);
  assign ehot = ext_vld && (ext_temp > EL);

  p_board_cut_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_en && pwr_en && bhot) |=> (!pwr_en && reset_cause == 4'd4));

  p_ext_cut_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_en && pwr_en && ehot && !bhot) |=> (!pwr_en && reset_cause == 4'd5));

  p_disabled_keeps_power_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_en && pwr_en) |=> pwr_en);

  p_period_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (period >= LO) && (period <= HI));

  p_restore_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> $past(sec_tick));

  p_cause_held_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> $stable(reset_cause));
endmodule

bind thermal_guard thermal_guard_chk #(
  .TEMP_W(TEMP_W), .BOARD_LIMIT(BOARD_LIMIT), .EXT_LIMIT(EXT_LIMIT),
  .MIN_S(MIN_S), .MAX_S(MAX_S), .SEC_W(SEC_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .prot_en(prot_en),
  .board_vld(board_vld), .board_temp(board_temp),
  .ext_vld(ext_vld), .ext_temp(ext_temp), .sec_tick(sec_tick),
  .pwr_en(pwr_en), .reset_cause(reset_cause), .period(cool_period)
);

// File: tb/thermal_guard_test.sv
`timescale 1ns/1ps
module thermal_guard_test;
  localparam int MIN_S = 2, MAX_S = 9, STEP_S = 3, QUIET_S = 6;
  localparam int BL = 850, EL = 1000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, prot_en, board_vld, ext_vld, sec_tick;
  logic signed [15:0] board_temp, ext_temp;
  logic pwr_en;
  logic [3:0] reset_cause;

  int checks = 0;
  int fails  = 0;
  int model_period;
  bit done = 0;

  thermal_guard #(
    .TEMP_W(16), .BOARD_LIMIT(BL), .EXT_LIMIT(EL),
    .MIN_S(MIN_S), .MAX_S(MAX_S), .STEP_S(STEP_S), .QUIET_S(QUIET_S)
  ) uut (
    .clk(clk), .rst_n(rst_n), .prot_en(prot_en),
    .board_vld(board_vld), .board_temp(board_temp),
    .ext_vld(ext_vld), .ext_temp(ext_temp), .sec_tick(sec_tick),
    .pwr_en(pwr_en), .reset_cause(reset_cause)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_out(input int pwr, input int cause, input string req);
    check(pwr_en == 1'(pwr), {req, " pwr_en"}, int'(pwr_en), pwr);
    check(reset_cause == 4'(cause), {req, " reset_cause"}, int'(reset_cause), cause);
  endtask

  // present one reading for a single cycle; outputs are due on the next falling edge
  task automatic present(input int bt, input bit bv, input int et, input bit ev);
    board_temp = 16'(bt); board_vld = bv;
    ext_temp   = 16'(et); ext_vld   = ev;
    @(negedge clk);
    board_vld = 1'b0; ext_vld = 1'b0;
  endtask

  task automatic tick();
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic cool_down(input int len, input int cause, input string req);
    for (int i = 1; i <= len; i++) begin
      tick();
      expect_out((i == len) ? 1 : 0, cause, req);
    end
  endtask

  task automatic trip_cycle(input int bt, input bit bv, input int et, input bit ev,
                            input int cause, input string req);
    present(bt, bv, et, ev);
    expect_out(0, cause, req);
    // R9: a hot reading of the other sensor while off must not change anything
    if (cause == 4) present(2000, 1'b0, 2000, 1'b1);
    else            present(2000, 1'b1, 2000, 1'b0);
    expect_out(0, cause, "R9 ignored while off");
    cool_down(model_period, cause, "R5/R6 cooldown length");
    model_period = (model_period + STEP_S > MAX_S) ? MAX_S : model_period + STEP_S;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; prot_en = 1'b0; sec_tick = 1'b0;
    board_vld = 1'b0; ext_vld = 1'b0; board_temp = '0; ext_temp = '0;
    model_period = MIN_S;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_out(1, 0, "R10 reset state");

    // R8: disabled, nothing cuts power
    present(2000, 1'b1, 2000, 1'b1);
    expect_out(1, 0, "R8 disabled");
    tick();
    expect_out(1, 0, "R8 disabled after tick");

    prot_en = 1'b1;
    // R1/R4: sweep board reading across its limit
    for (int t = BL - 3; t <= BL + 3; t++) begin
      if (t > BL) trip_cycle(t, 1'b1, 0, 1'b0, 4, "R1 board trip");
      else begin
        present(t, 1'b1, 0, 1'b0);
        expect_out(1, (t == BL - 3) ? 0 : 0, "R4 board at/below limit");
      end
    end

    // R7: full quiet span returns the period to minimum
    repeat (QUIET_S) tick();
    model_period = MIN_S;

    // R2/R4: sweep external reading across its limit
    for (int t = EL - 3; t <= EL + 3; t++) begin
      if (t > EL) trip_cycle(0, 1'b0, t, 1'b1, 5, "R2 external trip");
      else begin
        present(0, 1'b0, t, 1'b1);
        expect_out(1, 4, "R4 external at/below limit");
      end
    end

    // R6: period saturates at the ceiling
    trip_cycle(2000, 1'b1, 0, 1'b0, 4, "R6 clamp first");
    trip_cycle(2000, 1'b1, 0, 1'b0, 4, "R6 clamp second");

    // R7: one tick short of the quiet span keeps the grown period
    repeat (QUIET_S - 1) tick();
    trip_cycle(0, 1'b0, 1500, 1'b1, 5, "R7 short quiet keeps period");

    // R7 then R3: full quiet span, then both sensors hot together
    repeat (QUIET_S) tick();
    model_period = MIN_S;
    trip_cycle(1200, 1'b1, 1500, 1'b1, 4, "R3 both hot board wins");

    // R4: negative readings and hot readings with valid low
    present(-500, 1'b1, -32000, 1'b1);
    expect_out(1, 4, "R4 negative readings");
    present(2000, 1'b0, 2000, 1'b0);
    expect_out(1, 4, "R4 valid low");

    // R10: cause persists after restore
    repeat (2) tick();
    expect_out(1, 4, "R10 cause held");

    // R8: disabling again blocks a hot reading
    prot_en = 1'b0;
    present(2000, 1'b1, 0, 1'b0);
    expect_out(1, 4, "R8 disabled again");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule